// File: doc/BRIEF.md
# ATA Transfer Sequencer

This block takes a decoded ATA read, write or verify command and turns it into a sequence of sector data phases. It works out how many sectors the command moves, checks that the addressed range stays below a settable ceiling, and then steps through the sectors one by one. While it steps, it emits a data-request strobe and an interrupt pulse wherever the command's protocol puts block boundaries. Single-sector PIO commands interrupt on every sector. Multiple-mode commands interrupt once per block. DMA and verify commands interrupt once, at the end.

A command is offered with a one-cycle `cmd_valid` while the block is idle. The surrounding data mover signals with `data_rdy` that it can take or give a sector. Verify commands move no data, so they step one sector per cycle without waiting. Every command ends with a one-cycle `done_o`. For a command that fails, `idnf_o` or `abort_o` pulses in the same cycle. The data mover, DMA engines and the link are outside this block.

Top module: `ata_xfer_seq`

## Requirements
- R1: For 28-bit commands (opcodes 20h, 21h, 30h, 31h, C4h, C5h, C8h–CBh, 40h, 41h) only bits 7:0 of the count are used, and a value of 0 moves 256 sectors. Any other value moves exactly that many sectors.
- R2: For 48-bit commands (opcodes 24h, 25h, 29h, 34h, 35h, 39h, 42h) the full 16-bit count is used, and a value of 0 moves 65536 sectors.
- R3: Multiple-mode commands (C4h, C5h, 29h, 39h) give one DRQ and one interrupt per block, with the block size taken from `mult_cnt`. A shorter final block still gives its DRQ and its interrupt.
- R4: When `mult_cnt` is 0, meaning no set-multiple has succeeded, the block size is bits 7:0 of the stored identify word, which is 16 by default.
- R5: Verify commands (40h, 41h, 42h) produce one sector strobe per sector, never assert DRQ, and give a single interrupt at the end.
- R6: Single-sector PIO commands (20h, 21h, 24h, 30h, 31h, 34h) give one DRQ and one interrupt per sector.
- R7: DMA commands (C8h–CBh, 25h, 35h) give one DRQ at the start and one interrupt at the end. Every command ends with exactly one `done_o` pulse, and that pulse carries an interrupt.
- R8: When `max_en` is high and LBA + count − 1 exceeds `max_lba`, the command ends with `idnf_o`, `done_o` and `intr_o` and gives no DRQ and no sector strobe. 28-bit commands use only LBA bits 27:0. When `max_en` is low, no range check is made.
- R9: NOP (00h) and any opcode not listed above end with `abort_o`, `done_o` and `intr_o`, with no data phase.
- R10: `cmd_valid` is ignored while `busy_o` is high.
- R11: For non-verify commands, a sector is stepped only in a cycle where `data_rdy` is high.
- R12: After reset, all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command offer |
| cmd_op | input | 8 | Command opcode |
| cmd_cnt | input | 16 | Sector count field |
| cmd_lba | input | 48 | Starting LBA |
| mult_cnt | input | 8 | Current multiple setting, 0 = none set |
| max_lba | input | 48 | Highest allowed LBA |
| max_en | input | 1 | A set-max has completed |
| data_rdy | input | 1 | Data mover ready for one sector |
| busy_o | output | 1 | Command in progress |
| drq_o | output | 1 | Data-request strobe at block start |
| sect_o | output | 1 | One sector's data phase completed |
| intr_o | output | 1 | Interrupt pulse |
| idnf_o | output | 1 | Address range error |
| abort_o | output | 1 | Command aborted |
| done_o | output | 1 | Command finished |

## Verification
The assertions assume that the opcode seen with an accepted `cmd_valid` describes the command for its whole life, and that `data_rdy` is the only thing that gates stepping for non-verify commands. The bench holds every command input steady from the offer until `done_o`. It toggles `data_rdy` every cycle so that stalls and steps interleave, and it raises `cmd_valid` during a busy stretch only in the directed test that checks the offer is ignored.

// File: rtl/ata_xfer_pkg.sv
// Shared types for the ATA transfer sequencer.
// Assumes: opcode decoding yields one transfer kind plus an addressing width.
package ata_xfer_pkg;
    typedef enum logic [2:0] {
        XK_NONE,
        XK_PIO,
        XK_MULT,
        XK_DMA,
        XK_VERIFY
    } xfer_kind_t;

    typedef struct packed {
        xfer_kind_t kind;
        logic       ext48;
    } cmd_info_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_XFER
    } seq_state_t;
endpackage

// File: rtl/ata_cmd_decode.sv
// Maps an opcode to its transfer kind and addressing width.
// Assumes: unknown opcodes and NOP yield XK_NONE, which the sequencer aborts.
module ata_cmd_decode
    import ata_xfer_pkg::*;
(
    input  logic [7:0] op,
    output cmd_info_t  info
);
    // Purpose: opcode table lookup.
    always_comb begin
        info = '{kind: XK_NONE, ext48: 1'b0};
        case (op)
            8'h20, 8'h21, 8'h30, 8'h31: info = '{kind: XK_PIO,    ext48: 1'b0};
            8'h24, 8'h34:               info = '{kind: XK_PIO,    ext48: 1'b1};
            8'hC4, 8'hC5:               info = '{kind: XK_MULT,   ext48: 1'b0};
            8'h29, 8'h39:               info = '{kind: XK_MULT,   ext48: 1'b1};
            8'hC8, 8'hC9, 8'hCA, 8'hCB: info = '{kind: XK_DMA,    ext48: 1'b0};
            8'h25, 8'h35:               info = '{kind: XK_DMA,    ext48: 1'b1};
            8'h40, 8'h41:               info = '{kind: XK_VERIFY, ext48: 1'b0};
            8'h42:                      info = '{kind: XK_VERIFY, ext48: 1'b1};
            default:                    info = '{kind: XK_NONE,   ext48: 1'b0};
        endcase
    end
endmodule

// File: rtl/ata_len_calc.sv
// Expands the count field into a sector total, applying the zero convention
// of the addressing width.
// Assumes: LEN_W = CNT_W + 1 so that the largest total fits.
module ata_len_calc #(
    parameter int CNT_W   = 16,
    parameter int SHORT_W = 8,
    parameter int LEN_W   = CNT_W + 1
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             ext48,
    output logic [LEN_W-1:0] len
);
    localparam logic [LEN_W-1:0] SHORT_MAX = LEN_W'(1) << SHORT_W;
    localparam logic [LEN_W-1:0] LONG_MAX  = LEN_W'(1) << CNT_W;

    // Purpose: choose the field width and map zero to the maximum.
    always_comb begin
        if (ext48) begin
            len = (cnt == '0) ? LONG_MAX : LEN_W'(cnt);
        end else begin
            len = (cnt[SHORT_W-1:0] == '0) ? SHORT_MAX : LEN_W'(cnt[SHORT_W-1:0]);
        end
    end
endmodule

// File: rtl/ata_range_chk.sv
// Flags an access whose last sector lies above the ceiling.
// Assumes: len is at least 1, so the end address never underflows.
module ata_range_chk #(
    parameter int LBA_W       = 48,
    parameter int SHORT_LBA_W = 28,
    parameter int LEN_W       = 17
) (
    input  logic [LBA_W-1:0] lba,
    input  logic             ext48,
    input  logic [LEN_W-1:0] len,
    input  logic [LBA_W-1:0] max_lba,
    input  logic             max_en,
    output logic             over
);
    logic [LBA_W-1:0] lba_eff;
    logic [LBA_W:0]   last_addr;

    // Purpose: mask short addresses and compare the last sector to the ceiling.
    always_comb begin
        lba_eff   = ext48 ? lba : {{(LBA_W-SHORT_LBA_W){1'b0}}, lba[SHORT_LBA_W-1:0]};
        last_addr = {1'b0, lba_eff} + (LBA_W+1)'(len) - (LBA_W+1)'(1);
        over      = max_en && (last_addr > {1'b0, max_lba});
    end
endmodule

// File: rtl/ata_xfer_seq.sv
// Top of the ATA transfer sequencer: accepts a command, checks it, then steps
// sectors while emitting DRQ, sector, interrupt and completion pulses.
// Assumes: command inputs are held stable until done_o; mult_cnt of zero
// means no set-multiple has succeeded.
module ata_xfer_seq
    import ata_xfer_pkg::*;
#(
    parameter int          LBA_W       = 48,
    parameter int          CNT_W       = 16,
    parameter int          SHORT_W     = 8,
    parameter int          SHORT_LBA_W = 28,
    parameter int          MULT_W      = 8,
    parameter logic [15:0] IDENT_MULT  = 16'h8010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_cnt,
    input  logic [LBA_W-1:0]  cmd_lba,
    input  logic [MULT_W-1:0] mult_cnt,
    input  logic [LBA_W-1:0]  max_lba,
    input  logic              max_en,
    input  logic              data_rdy,
    output logic              busy_o,
    output logic              drq_o,
    output logic              sect_o,
    output logic              intr_o,
    output logic              idnf_o,
    output logic              abort_o,
    output logic              done_o
);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [MULT_W-1:0] DFLT_MULT = IDENT_MULT[MULT_W-1:0];

    cmd_info_t        info;
    logic [LEN_W-1:0] len;
    logic             over;
    logic [LEN_W-1:0] blk_sel;

    seq_state_t       st;
    xfer_kind_t       kind_q;
    logic             over_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] blk_len_q;
    logic [LEN_W-1:0] blk_left_q;
    logic             drq_q, sect_q, intr_q, idnf_q, abort_q, done_q;

    ata_cmd_decode u_dec (
        .op   (cmd_op),
        .info (info)
    );

    ata_len_calc #(.CNT_W(CNT_W), .SHORT_W(SHORT_W), .LEN_W(LEN_W)) u_len (
        .cnt   (cmd_cnt),
        .ext48 (info.ext48),
        .len   (len)
    );

    ata_range_chk #(.LBA_W(LBA_W), .SHORT_LBA_W(SHORT_LBA_W), .LEN_W(LEN_W)) u_rng (
        .lba     (cmd_lba),
        .ext48   (info.ext48),
        .len     (len),
        .max_lba (max_lba),
        .max_en  (max_en),
        .over    (over)
    );

    // Purpose: pick the interrupt block length for the decoded kind.
    always_comb begin
        case (info.kind)
            XK_PIO:  blk_sel = LEN_W'(1);
            XK_MULT: blk_sel = (mult_cnt != '0) ? LEN_W'(mult_cnt) : LEN_W'(DFLT_MULT);
            default: blk_sel = len;
        endcase
    end

    logic adv, last, blk_end;

    // Purpose: decide whether the current cycle steps a sector and where it falls.
    always_comb begin
        adv     = (st == ST_XFER) && ((kind_q == XK_VERIFY) || data_rdy);
        last    = (remain_q == LEN_W'(1));
        blk_end = last || (blk_left_q == LEN_W'(1));
    end

    // Purpose: command state machine, sector counters and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            kind_q     <= XK_NONE;
            over_q     <= 1'b0;
            remain_q   <= '0;
            blk_len_q  <= '0;
            blk_left_q <= '0;
            drq_q      <= 1'b0;
            sect_q     <= 1'b0;
            intr_q     <= 1'b0;
            idnf_q     <= 1'b0;
            abort_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            drq_q   <= 1'b0;
            sect_q  <= 1'b0;
            intr_q  <= 1'b0;
            idnf_q  <= 1'b0;
            abort_q <= 1'b0;
            done_q  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        kind_q     <= info.kind;
                        over_q     <= over;
                        remain_q   <= len;
                        blk_len_q  <= blk_sel;
                        blk_left_q <= blk_sel;
                        st         <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (kind_q == XK_NONE) begin
                        abort_q <= 1'b1;
                        intr_q  <= 1'b1;
                        done_q  <= 1'b1;
                        st      <= ST_IDLE;
                    end else if (over_q) begin
                        idnf_q <= 1'b1;
                        intr_q <= 1'b1;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        drq_q <= (kind_q != XK_VERIFY);
                        st    <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (adv) begin
                        sect_q     <= 1'b1;
                        remain_q   <= remain_q - LEN_W'(1);
                        blk_left_q <= blk_end ? blk_len_q : blk_left_q - LEN_W'(1);
                        intr_q     <= blk_end;
                        if (last) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else if (blk_end && (kind_q != XK_VERIFY)) begin
                            drq_q <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (st != ST_IDLE);
    assign drq_o   = drq_q;
    assign sect_o  = sect_q;
    assign intr_o  = intr_q;
    assign idnf_o  = idnf_q;
    assign abort_o = abort_q;
    assign done_o  = done_q;
endmodule

// File: rtl/ata_xfer_seq_chk.sv
// Property checker for the ATA transfer sequencer, bound to its top.
// Assumes: the opcode offered with an accepted cmd_valid names the command.
module ata_xfer_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       data_rdy,
    input logic       busy_o,
    input logic       drq_o,
    input logic       sect_o,
    input logic       intr_o,
    input logic       idnf_o,
    input logic       abort_o,
    input logic       done_o
);
    logic chk_verify;

    // Purpose: remember whether the accepted command is a verify.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_verify <= 1'b0;
        end else if (cmd_valid && !busy_o) begin
            chk_verify <= (cmd_op == 8'h40) || (cmd_op == 8'h41) || (cmd_op == 8'h42);
        end
    end

    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (idnf_o || abort_o) |-> (done_o && intr_o)); // R8
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idnf_o, abort_o, sect_o})); // R9
    AST_DONE_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> intr_o); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !data_rdy && !chk_verify) |=> !sect_o); // R11
    AST_VERIFY_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        chk_verify |-> !drq_o); // R5
    AST_SECT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sect_o |-> $past(busy_o)); // R11
    AST_DRQ_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        drq_o |-> busy_o); // R6
endmodule

bind ata_xfer_seq ata_xfer_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .data_rdy  (data_rdy),
    .busy_o    (busy_o),
    .drq_o     (drq_o),
    .sect_o    (sect_o),
    .intr_o    (intr_o),
    .idnf_o    (idnf_o),
    .abort_o   (abort_o),
    .done_o    (done_o)
);

// File: tb/sim_ata_xfer_seq.sv
module sim_ata_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [15:0] cmd_cnt = '0;
    logic [47:0] cmd_lba = '0;
    logic [7:0]  mult_cnt = '0;
    logic [47:0] max_lba = '0;
    logic        max_en = 1'b0;
    logic        data_rdy = 1'b0;
    logic busy_o, drq_o, sect_o, intr_o, idnf_o, abort_o, done_o;

    always #2.5 clk = ~clk;

    ata_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cnt(cmd_cnt), .cmd_lba(cmd_lba), .mult_cnt(mult_cnt),
        .max_lba(max_lba), .max_en(max_en), .data_rdy(data_rdy),
        .busy_o(busy_o), .drq_o(drq_o), .sect_o(sect_o), .intr_o(intr_o),
        .idnf_o(idnf_o), .abort_o(abort_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [7:0]  op;
        logic [15:0] cnt;
        logic [47:0] lba;
        logic [7:0]  mult;
        logic [47:0] mx;
        logic        mxen;
        logic [16:0] e_sect;
        logic [16:0] e_drq;
        logic [16:0] e_intr;
        logic        e_idnf;
        logic        e_abort;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{"R6 ", 8'h20, 16'd3,      48'd100, 8'd0, 48'd0,   1'b0, 17'd3,   17'd3,   17'd3,   1'b0, 1'b0},
        '{"R1 ", 8'h20, 16'd0,      48'd0,   8'd0, 48'd0,   1'b0, 17'd256, 17'd256, 17'd256, 1'b0, 1'b0},
        '{"R1 ", 8'h30, 16'h0105,   48'd7,   8'd0, 48'd0,   1'b0, 17'd5,   17'd5,   17'd5,   1'b0, 1'b0},
        '{"R7 ", 8'hC8, 16'd4,      48'd9,   8'd0, 48'd0,   1'b0, 17'd4,   17'd1,   17'd1,   1'b0, 1'b0},
        '{"R2 ", 8'h35, 16'd300,    48'd9,   8'd0, 48'd0,   1'b0, 17'd300, 17'd1,   17'd1,   1'b0, 1'b0},
        '{"R3 ", 8'hC4, 16'd10,     48'd0,   8'd4, 48'd0,   1'b0, 17'd10,  17'd3,   17'd3,   1'b0, 1'b0},
        '{"R4 ", 8'h39, 16'd40,     48'd0,   8'd0, 48'd0,   1'b0, 17'd40,  17'd3,   17'd3,   1'b0, 1'b0},
        '{"R3 ", 8'hC5, 16'd8,      48'd0,   8'd8, 48'd0,   1'b0, 17'd8,   17'd1,   17'd1,   1'b0, 1'b0},
        '{"R5 ", 8'h40, 16'd7,      48'd0,   8'd0, 48'd0,   1'b0, 17'd7,   17'd0,   17'd1,   1'b0, 1'b0},
        '{"R8 ", 8'h24, 16'd2,      48'd998, 8'd0, 48'd999, 1'b1, 17'd2,   17'd2,   17'd2,   1'b0, 1'b0},
        '{"R8 ", 8'h24, 16'd3,      48'd998, 8'd0, 48'd999, 1'b1, 17'd0,   17'd0,   17'd1,   1'b1, 1'b0},
        '{"R8 ", 8'h24, 16'd3,      48'd998, 8'd0, 48'd999, 1'b0, 17'd3,   17'd3,   17'd3,   1'b0, 1'b0},
        '{"R9 ", 8'h00, 16'd5,      48'd0,   8'd0, 48'd0,   1'b0, 17'd0,   17'd0,   17'd1,   1'b0, 1'b1},
        '{"R9 ", 8'hE7, 16'd5,      48'd0,   8'd0, 48'd0,   1'b0, 17'd0,   17'd0,   17'd1,   1'b0, 1'b1},
        '{"R8 ", 8'hC8, 16'd0,      48'd0,   8'd0, 48'd255, 1'b1, 17'd256, 17'd1,   17'd1,   1'b0, 1'b0},
        '{"R8 ", 8'h20, 16'd1,      48'h1_0000_0010, 8'd0, 48'h20, 1'b1, 17'd1, 17'd1, 17'd1, 1'b0, 1'b0},
        '{"R2 ", 8'h42, 16'd0,      48'd0,   8'd0, 48'd0,   1'b0, 17'd65536, 17'd0, 17'd1,   1'b0, 1'b0}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit hung = 1'b0;
    int c_sect, c_drq, c_intr, c_idnf, c_abort, c_done;

    task automatic clear_counts();
        c_sect = 0; c_drq = 0; c_intr = 0; c_idnf = 0; c_abort = 0; c_done = 0;
    endtask

    task automatic sample();
        c_sect  += int'(sect_o);
        c_drq   += int'(drq_o);
        c_intr  += int'(intr_o);
        c_idnf  += int'(idnf_o);
        c_abort += int'(abort_o);
        c_done  += int'(done_o);
    endtask

    // Runs until done_o is seen; data_rdy toggles every cycle.
    task automatic run_to_done();
        for (int i = 0; i < 140000; i++) begin
            @(negedge clk);
            sample();
            if (done_o) return;
            data_rdy = ~data_rdy;
        end
        hung = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: command never finished, actual done=0 expected done=1");
    endtask

    task automatic offer(input vec_t v);
        @(negedge clk);
        cmd_op = v.op; cmd_cnt = v.cnt; cmd_lba = v.lba; mult_cnt = v.mult;
        max_lba = v.mx; max_en = v.mxen; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        clear_counts();
        sample();
    endtask

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if ({busy_o, drq_o, sect_o, intr_o, idnf_o, abort_o, done_o} !== 7'b0) begin
            n_bad++;
            $display("FAIL R12 reset outputs actual=%b expected=0000000",
                     {busy_o, drq_o, sect_o, intr_o, idnf_o, abort_o, done_o});
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (busy_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 idle after reset actual busy=%b expected=0", busy_o);
        end

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            if (!hung) begin
                data_rdy = 1'b0;
                offer(VEC[k]);
                if (!done_o) run_to_done();
                n_chk++;
                if (c_sect != int'(VEC[k].e_sect) || c_drq != int'(VEC[k].e_drq) ||
                    c_intr != int'(VEC[k].e_intr) || c_idnf != int'(VEC[k].e_idnf) ||
                    c_abort != int'(VEC[k].e_abort) || c_done != 1) begin
                    n_bad++;
                    $display("FAIL %s vec %0d op=%h actual sect=%0d drq=%0d intr=%0d idnf=%0d abort=%0d done=%0d expected sect=%0d drq=%0d intr=%0d idnf=%0d abort=%0d done=1",
                             VEC[k].tag, k, VEC[k].op, c_sect, c_drq, c_intr, c_idnf, c_abort, c_done,
                             VEC[k].e_sect, VEC[k].e_drq, VEC[k].e_intr, VEC[k].e_idnf, VEC[k].e_abort);
                end
            end
        end

        // R11 and R10: stall, and an offer during busy is ignored.
        if (!hung) begin
            data_rdy = 1'b0;
            offer('{"R11", 8'h20, 16'd2, 48'd0, 8'd0, 48'd0, 1'b0, 17'd0, 17'd0, 17'd0, 1'b0, 1'b0});
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (i == 3) begin
                    cmd_op = 8'h00; cmd_valid = 1'b1;
                end else begin
                    cmd_valid = 1'b0;
                end
                sample();
            end
            cmd_valid = 1'b0;
            n_chk++;
            if (c_sect != 0 || busy_o !== 1'b1) begin
                n_bad++;
                $display("FAIL R11 stalled command actual sect=%0d busy=%b expected sect=0 busy=1",
                         c_sect, busy_o);
            end
            data_rdy = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                sample();
                if (done_o) break;
            end
            n_chk++;
            if (c_sect != 2 || c_abort != 0 || c_done != 1 || c_drq != 2) begin
                n_bad++;
                $display("FAIL R10 busy offer ignored actual sect=%0d abort=%0d done=%0d drq=%0d expected 2 0 1 2",
                         c_sect, c_abort, c_done, c_drq);
            end
            repeat (3) @(negedge clk);
            n_chk++;
            if (busy_o !== 1'b0 || abort_o !== 1'b0) begin
                n_bad++;
                $display("FAIL R10 no late command actual busy=%b abort=%b expected 0 0",
                         busy_o, abort_o);
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule